// File: doc/BRIEF.md
# Opcode-Steered Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. It takes a destination operand, a source operand, the current carry flag and an 8-bit opcode. It returns a result word, a flag vector and a flag write-enable mask. The surrounding sequencer writes the result back and updates only the flag bits whose mask bit is set. The block holds no state. Register reads, instruction sequencing and flag storage belong to the logic around it.

The opcode is not decoded into a separate internal command. Its bits steer the datapath directly. Bit 5 turns the adder into a subtractor. Bit 4 replaces the source operand with the constant one. Bit 0 sets the direction of the combined shift and rotate unit, and bit 4 selects rotate over shift through carry. The adder is built as a chain of 4-bit stages, so the carries between nibbles appear as flags next to the final carry.

Top module: `alu16_top`

## Requirements
- R1: Opcode 0x45 returns (dst + src) modulo 2^16. The carry flag (bit 0) is the carry out of bit 15.
- R2: Opcode 0x65 returns (dst - src) modulo 2^16. The carry flag reads 1 exactly when src > dst as unsigned values, which is a borrow.
- R3: Opcodes 0x55 and 0x75 behave as 0x45 and 0x65 with the source operand replaced by the constant 1, so they increment and decrement dst.
- R4: For the four arithmetic opcodes, flag bits 1, 2 and 3 give the carry out of result bits 3, 7 and 11. When subtracting, they give the borrow out of those bits instead.
- R5: For the arithmetic opcodes, flag bit 4 (zero) is set when the result is 0. Flag bit 5 (negative) equals result bit 15. Flag bit 6 (overflow) flags signed two's-complement overflow. All seven flag bits are enabled.
- R6: Opcode 0x40 returns ~dst, 0x41 returns dst ^ src, 0x42 returns dst & src and 0x43 returns dst | src. Only the zero flag (bit 4) is enabled.
- R7: Opcode 0x46 returns {dst[14:0], cin} and sets carry to dst[15]. Opcode 0x47 returns {cin, dst[15:1]} and sets carry to dst[0]. Only the carry and zero flags (bits 0 and 4) are enabled.
- R8: Opcode 0x56 returns {dst[14:0], dst[15]}. Opcode 0x57 returns {dst[0], dst[15:1]}. No flag is enabled.
- R9: Opcode 0x48 returns dst with its high and low bytes exchanged. No flag is enabled.
- R10: Any other opcode returns dst unchanged with an all-zero flag mask.
- R11: Every flag bit whose mask bit is 0 reads 0.
- R12: The carry-in input affects only opcodes 0x46 and 0x47. Every other opcode gives the same result, flags and mask for either value of the carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opc_i | input | 8 | Operation code |
| dst_i | input | 16 | Destination operand, also the first operand |
| src_i | input | 16 | Source operand |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 16 | Result word |
| flg_o | output | 7 | Flags: 0 carry, 1..3 nibble carries, 4 zero, 5 negative, 6 overflow |
| fwe_o | output | 7 | Per-flag write enable, same bit layout as flg_o |

## Verification
The embedded immediate checks assume that every input holds a defined 0 or 1 value. They also assume that the outputs are evaluated only after the combinational paths have settled. A check that fired on a transient value would report a false failure. The bench holds all four inputs constant from one rising edge to the next and reads the outputs at the falling edge in between. The sweep visits every one of the 256 opcodes, with both carry-in values and a grid of corner and pseudo-random operand pairs. These include all-ones, the sign boundary and nibble-boundary values, so every nibble carry and borrow and both overflow directions occur.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   // Coarse operation class derived from the opcode bits
   typedef enum logic [2:0] {
      K_NONE,
      K_ARITH,
      K_LOGIC,
      K_SHIFT,
      K_ROT,
      K_SWAP
   } kind_t;

   // Flag vector layout: carry at 0, nibble taps above it, then zero, negative, overflow
   function automatic int nib_count(input int width);
      return width / 4;
   endfunction

   function automatic int flag_width(input int width);
      return nib_count(width) + 3;
   endfunction

   function automatic int zero_pos(input int width);
      return nib_count(width);
   endfunction

   function automatic int neg_pos(input int width);
      return nib_count(width) + 1;
   endfunction

   function automatic int ovf_pos(input int width);
      return nib_count(width) + 2;
   endfunction

endpackage

// File: rtl/alu16_adder.sv
module alu16_adder
   import alu16_pkg::*;
#(
   parameter  int WIDTH = 16,
   localparam int NNIB  = WIDTH / 4
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             sub_i,
   input  logic             one_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic [NNIB-2:0]  tap_o,
   output logic             ovf_o
);

   logic [WIDTH-1:0] opnd;
   logic [WIDTH-1:0] opx;
   logic [NNIB:0]    cy;

   assign opnd  = one_i ? WIDTH'(1) : b_i;
   assign opx   = sub_i ? ~opnd : opnd;
   assign cy[0] = sub_i;

   generate
      for (genvar k = 0; k < NNIB; k++) begin : g_nib
         logic [4:0] part;
         assign part = {1'b0, a_i[4*k +: 4]} + {1'b0, opx[4*k +: 4]} + {4'b0, cy[k]};
         assign sum_o[4*k +: 4] = part[3:0];
         assign cy[k+1]         = part[4];
      end
      for (genvar k = 1; k < NNIB; k++) begin : g_tap
         assign tap_o[k-1] = cy[k] ^ sub_i;
      end
   endgenerate

   assign cout_o = cy[NNIB] ^ sub_i;
   assign ovf_o  = (a_i[WIDTH-1] == opx[WIDTH-1]) && (sum_o[WIDTH-1] != a_i[WIDTH-1]);

   // Checks against plain arithmetic, independent of the nibble chain
   logic signed [WIDTH:0] chk_wide;
   always_comb begin
      chk_wide = sub_i ? ($signed({a_i[WIDTH-1], a_i}) - $signed({opnd[WIDTH-1], opnd}))
                       : ($signed({a_i[WIDTH-1], a_i}) + $signed({opnd[WIDTH-1], opnd}));
      if (!sub_i) begin
         p_add_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, opnd}));
      end else begin
         p_sub_borrow_r2: assert ((sum_o == a_i - opnd) && (cout_o == (a_i < opnd)));
      end
      p_signed_ovf_r5: assert (ovf_o == (chk_wide[WIDTH] != chk_wide[WIDTH-1]));
   end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic #(
   parameter int WIDTH = 16
) (
   input  logic [1:0]       sel_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] res_o
);

   always_comb begin
      unique case (sel_i)
         2'b00:   res_o = ~a_i;
         2'b01:   res_o = a_i ^ b_i;
         2'b10:   res_o = a_i & b_i;
         default: res_o = a_i | b_i;
      endcase
   end

   always_comb begin
      if (sel_i == 2'b00) begin
         p_not_inverts_r6: assert ((res_o ^ a_i) == {WIDTH{1'b1}});
      end
   end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift #(
   parameter int WIDTH = 16
) (
   input  logic             right_i,
   input  logic             rot_i,
   input  logic [WIDTH-1:0] a_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic             cout_o
);

   logic fill_lo;
   logic fill_hi;

   assign fill_lo = rot_i ? a_i[WIDTH-1] : cin_i;
   assign fill_hi = rot_i ? a_i[0]       : cin_i;
   assign cout_o  = right_i ? a_i[0] : a_i[WIDTH-1];

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic from_lo;
         logic from_hi;
         if (b == 0) begin : g_lsb
            assign from_lo = fill_lo;
         end else begin : g_mid_lo
            assign from_lo = a_i[b-1];
         end
         if (b == WIDTH - 1) begin : g_msb
            assign from_hi = fill_hi;
         end else begin : g_mid_hi
            assign from_hi = a_i[b+1];
         end
         assign res_o[b] = right_i ? from_hi : from_lo;
      end
   endgenerate

   always_comb begin
      if (rot_i) begin
         p_rot_keeps_ones_r8: assert ($countones(res_o) == $countones(a_i));
      end else begin
         p_shift_conserves_r7: assert (($countones(res_o) + 32'(cout_o)) ==
                                       ($countones(a_i) + 32'(cin_i)));
      end
   end

endmodule

// File: rtl/alu16_top.sv
module alu16_top
   import alu16_pkg::*;
#(
   parameter  int WIDTH = 16,
   localparam int NNIB  = nib_count(WIDTH),
   localparam int FLW   = flag_width(WIDTH)
) (
   input  logic [7:0]       opc_i,
   input  logic [WIDTH-1:0] dst_i,
   input  logic [WIDTH-1:0] src_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] res_o,
   output logic [FLW-1:0]   flg_o,
   output logic [FLW-1:0]   fwe_o
);

   localparam int FZ   = zero_pos(WIDTH);
   localparam int FN   = neg_pos(WIDTH);
   localparam int FO   = ovf_pos(WIDTH);
   localparam int HALF = WIDTH / 2;

   generate
      if (WIDTH < 8 || (WIDTH % 8) != 0) begin : g_bad_width
         $error("alu16_top: WIDTH must be a multiple of 8");
      end
   endgenerate

   kind_t kind;

   always_comb begin
      kind = K_NONE;
      if (opc_i[7:6] == 2'b01) begin
         if (opc_i[3:0] == 4'b0101)
            kind = K_ARITH;
         else if (opc_i[5:2] == 4'b0000)
            kind = K_LOGIC;
         else if (!opc_i[5] && opc_i[3:1] == 3'b011)
            kind = opc_i[4] ? K_ROT : K_SHIFT;
         else if (opc_i[5:0] == 6'h08)
            kind = K_SWAP;
      end
   end

   logic [WIDTH-1:0] add_res;
   logic             add_c;
   logic [NNIB-2:0]  add_taps;
   logic             add_v;
   logic [WIDTH-1:0] log_res;
   logic [WIDTH-1:0] sh_res;
   logic             sh_c;
   logic [WIDTH-1:0] swp_res;

   alu16_adder #(.WIDTH(WIDTH)) i_adder (
      .a_i    (dst_i),
      .b_i    (src_i),
      .sub_i  (opc_i[5]),
      .one_i  (opc_i[4]),
      .sum_o  (add_res),
      .cout_o (add_c),
      .tap_o  (add_taps),
      .ovf_o  (add_v)
   );

   alu16_logic #(.WIDTH(WIDTH)) i_logic (
      .sel_i (opc_i[1:0]),
      .a_i   (dst_i),
      .b_i   (src_i),
      .res_o (log_res)
   );

   alu16_shift #(.WIDTH(WIDTH)) i_shift (
      .right_i (opc_i[0]),
      .rot_i   (opc_i[4]),
      .a_i     (dst_i),
      .cin_i   (cin_i),
      .res_o   (sh_res),
      .cout_o  (sh_c)
   );

   assign swp_res = {dst_i[HALF-1:0], dst_i[WIDTH-1:HALF]};

   always_comb begin
      res_o = dst_i;
      flg_o = '0;
      fwe_o = '0;
      unique case (kind)
         K_ARITH: begin
            res_o          = add_res;
            flg_o[0]       = add_c;
            flg_o[NNIB-1:1] = add_taps;
            flg_o[FZ]      = (add_res == '0);
            flg_o[FN]      = add_res[WIDTH-1];
            flg_o[FO]      = add_v;
            fwe_o          = '1;
         end
         K_LOGIC: begin
            res_o     = log_res;
            flg_o[FZ] = (log_res == '0);
            fwe_o[FZ] = 1'b1;
         end
         K_SHIFT: begin
            res_o     = sh_res;
            flg_o[0]  = sh_c;
            flg_o[FZ] = (sh_res == '0);
            fwe_o[0]  = 1'b1;
            fwe_o[FZ] = 1'b1;
         end
         K_ROT:  res_o = sh_res;
         K_SWAP: res_o = swp_res;
         default: ;
      endcase
   end

   always_comb begin
      p_gated_flags_r11: assert ((flg_o & ~fwe_o) == '0);
   end

endmodule

// File: tb/test_alu16_top.sv
module test_alu16_top;

   localparam int W = 16;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [7:0]  opc;
   logic [W-1:0] dst;
   logic [W-1:0] src;
   logic        cin;
   logic [W-1:0] res;
   logic [6:0]  flg;
   logic [6:0]  fwe;

   int n_chk  = 0;
   int n_fail = 0;

   always #4 clk = ~clk;  // 125 MHz

   alu16_top #(.WIDTH(W)) i_alu16_top (
      .opc_i (opc),
      .dst_i (dst),
      .src_i (src),
      .cin_i (cin),
      .res_o (res),
      .flg_o (flg),
      .fwe_o (fwe)
   );

   function automatic string tag_of(input int cls);
      case (cls)
         1:  return "R1";
         2:  return "R2";
         3:  return "R3";
         6:  return "R6";
         7:  return "R7";
         8:  return "R8";
         9:  return "R9";
         default: return "R10";
      endcase
   endfunction

   // Independent reference computed from the requirements
   task automatic model(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic ci, output logic [15:0] r, output logic [6:0] f,
                        output logic [6:0] m, output int cls);
      logic [16:0] full;
      logic [15:0] bb;
      logic        subf;
      r = a; f = '0; m = '0; cls = 10;
      if (op == 8'h45 || op == 8'h55 || op == 8'h65 || op == 8'h75) begin
         subf = op[5];
         bb   = op[4] ? 16'd1 : b;
         cls  = op[4] ? 3 : (subf ? 2 : 1);
         if (!subf) begin
            full = {1'b0, a} + {1'b0, bb};
            r    = full[15:0];
            f[0] = full[16];
            for (int k = 1; k < 4; k++) begin
               logic [16:0] lm;
               lm   = (17'd1 << (4*k)) - 17'd1;
               full = ({1'b0, a} & lm) + ({1'b0, bb} & lm);
               f[k] = full[4*k];
            end
            f[6] = (a[15] == bb[15]) && (r[15] != a[15]);
         end else begin
            r    = a - bb;
            f[0] = a < bb;
            for (int k = 1; k < 4; k++) begin
               logic [15:0] lm;
               lm   = (16'd1 << (4*k)) - 16'd1;
               f[k] = (a & lm) < (bb & lm);
            end
            f[6] = (a[15] != bb[15]) && (r[15] != a[15]);
         end
         f[4] = (r == 16'd0);
         f[5] = r[15];
         m    = 7'h7F;
      end else if (op >= 8'h40 && op <= 8'h43) begin
         cls = 6;
         case (op[1:0])
            2'd0: r = ~a;
            2'd1: r = a ^ b;
            2'd2: r = a & b;
            default: r = a | b;
         endcase
         f[4] = (r == 16'd0);
         m    = 7'b001_0000;
      end else if (op == 8'h46 || op == 8'h47) begin
         cls  = 7;
         r    = op[0] ? {ci, a[15:1]} : {a[14:0], ci};
         f[0] = op[0] ? a[0] : a[15];
         f[4] = (r == 16'd0);
         m    = 7'b001_0001;
      end else if (op == 8'h56 || op == 8'h57) begin
         cls = 8;
         r   = op[0] ? {a[0], a[15:1]} : {a[14:0], a[15]};
      end else if (op == 8'h48) begin
         cls = 9;
         r   = {a[7:0], a[15:8]};
      end
   endtask

   task automatic compare(input string tag, input string what, input logic [15:0] act,
                          input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s op=%h dst=%h src=%h cin=%b actual=%h expected=%h",
                  tag, what, opc, dst, src, cin, act, exp);
      end
   endtask

   task automatic apply(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b,
                        input logic ci);
      logic [15:0] er;
      logic [6:0]  ef;
      logic [6:0]  em;
      int          cls;
      string       t;
      string       ft;
      @(posedge clk);
      opc = op; dst = a; src = b; cin = ci;
      @(negedge clk);
      model(op, a, b, ci, er, ef, em, cls);
      t = tag_of(cls);
      // R12: arithmetic and other non-shift ops must ignore cin
      if (ci && cls != 7) t = "R12";
      compare(t, "result", res, er);
      ft = t;
      if (cls <= 3 && flg[3:1] !== ef[3:1]) ft = "R4";
      else if (cls <= 3 && flg[6:4] !== ef[6:4]) ft = "R5";
      compare(ft, "flags", {9'd0, flg}, {9'd0, ef});
      compare(t, "mask", {9'd0, fwe}, {9'd0, em});
      compare("R11", "gated", {9'd0, flg & ~fwe}, 16'd0);
   endtask

   function automatic logic [15:0] lfsr(input logic [15:0] s);
      return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] pat [10];
      logic [15:0] seed;
      seed = 16'hACE1;
      opc = 8'h00; dst = '0; src = '0; cin = 1'b0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // Reset-time state: all-zero inputs, opcode 0x00 is unassigned (R10)
      compare("R10", "idle result", res, 16'd0);
      compare("R10", "idle mask", {9'd0, fwe}, 16'd0);

      // Directed corners
      apply(8'h45, 16'h7FFF, 16'h0001, 1'b0);  // R5 positive overflow
      apply(8'h65, 16'h8000, 16'h0001, 1'b0);  // R5 negative overflow
      apply(8'h55, 16'hFFFF, 16'h1234, 1'b0);  // R3 increment wraps, R1 carry
      apply(8'h75, 16'h0000, 16'h1234, 1'b0);  // R3 decrement borrows, R4 all taps
      apply(8'h45, 16'h0FFF, 16'h0001, 1'b0);  // R4 carries at 3,7,11
      apply(8'h99, 16'hBEEF, 16'h1111, 1'b1);  // R10 unassigned opcode

      for (int op = 0; op < 256; op++) begin
         pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h8000;
         pat[3] = 16'h7FFF; pat[4] = 16'h000F; pat[5] = 16'h0FF1;
         for (int p = 6; p < 10; p++) begin
            seed   = lfsr(seed);
            pat[p] = seed;
         end
         for (int ci = 0; ci < 2; ci++)
            for (int i = 0; i < 10; i++)
               for (int j = 0; j < 10; j++)
                  apply(8'(op), pat[i], pat[j], 1'(ci));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule